// File: doc/BRIEF.md
# Configurable Serial Peripheral Master with Word Queues

The block drives a four-wire serial bus as its master. Words written by the host land in a transmit queue. An engine takes them one at a time and shifts each onto the data-out pin. At the same time it captures the data-in pin into a receive word. After the last bit the receive word is pushed into a receive queue, where the host reads it.

Settings are presented on configuration inputs and take effect when the host pulses the restart strobe; until then, the values given at power-on reset apply. The settings are:
- word length (1 to 32 bits);
- clock half-period (1 to 256 clock cycles);
- bit order;
- sampling edge;
- clock rest level;
- write-only operation;
- select framing, where the select line either spans all data bits or gives single half-period pulses before the word, after it, or both;
- select polarity.

Status outputs report free transmit entries, stored receive words, an idle flag and a sticky receive-overflow flag.

Top module: `spi_fifo_master`

## Requirements
- R1: A word carries `cfg_len_m1_i + 1` bits, from 1 to 32; the value after rst_ni is 8 bits.
- R2: Each clock level of a data bit lasts `cfg_half_i + 1` cycles of clk_i (0 gives the fastest clock); the value after rst_ni is 0.
- R3: With `cfg_msb_first_i`=1, bit N-1 is sent first and the first received bit lands in bit N-1. With 0, bit 0 goes first on both sides. The value after rst_ni is 0.
- R4: With `cfg_sample_fall_i`=0, data-in is captured on the rising clock edge and data-out changes only on falling edges. With 1 the roles of the edges swap. The value after rst_ni is 0.
- R5: Outside data bits, including during select pulses, the clock rests at `cfg_cpol_i`; the value after rst_ni is 0.
- R6: `cfg_frame_mode_i` is a 2-bit code:
  - Code 0 holds select active over all 2N data half-periods.
  - Bit 0 adds a pulse before the word. The pulse lasts one half-period and ends one half-period before the first data bit.
  - Bit 1 adds a pulse after the word. It begins one half-period after the last data bit and lasts one half-period.
  - With a nonzero code, select stays inactive during the data bits.
- R7: With `cfg_ss_low_i`=1 the active select level is 0, otherwise 1; the value after rst_ni is 0.
- R8: With `cfg_write_only_i`=1, finished words are not stored in the receive queue.
- R9: A word that finishes while the receive queue is full and not being popped is dropped and sets `rx_overflow_o`. The flag stays set until `clr_rx_i`.
- R10: `restart_i` aborts any word in flight without storing it, empties the transmit queue, loads the configuration inputs and leaves the receive queue untouched; the clock returns to its new rest level.
- R11: `clr_rx_i` empties the receive queue and clears the overflow flag without touching transmit traffic.
- R12: `tx_space_o` is TX_DEPTH minus queued words. A load into a full transmit queue is ignored. A load in the same cycle the engine takes a word is accepted. `idle_o` is 1 only when the queue is empty and no word is in flight.
- R13: The received word holds the data-in bits in the order of R3, is presented on `rx_data_o` oldest first and is removed by `rx_pop_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len_m1_i | input | 5 | Word length minus one |
| cfg_half_i | input | 8 | Half-period count |
| cfg_msb_first_i | input | 1 | Bit order select |
| cfg_sample_fall_i | input | 1 | Sample on falling edge |
| cfg_cpol_i | input | 1 | Clock rest level |
| cfg_frame_mode_i | input | 2 | Select framing code |
| cfg_ss_low_i | input | 1 | Select active low |
| cfg_write_only_i | input | 1 | Skip receive storage |
| restart_i | input | 1 | Abort, flush transmit, apply settings |
| load_i | input | 1 | Push load_data_i into transmit queue |
| load_data_i | input | 32 | Word to send |
| clr_rx_i | input | 1 | Empty receive queue |
| rx_pop_i | input | 1 | Remove oldest received word |
| miso_i | input | 1 | Serial data in |
| rx_data_o | output | 32 | Oldest received word |
| tx_space_o | output | 3 | Free transmit entries |
| rx_count_o | output | 3 | Stored receive words |
| idle_o | output | 1 | Nothing pending or in flight |
| rx_overflow_o | output | 1 | Sticky receive overflow |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| ss_o | output | 1 | Select |

## Verification
Two events can land on the same clock edge:
- the engine taking a word from the transmit queue, and
- a host load into that queue.

The bench provokes this by loading two words on consecutive cycles into an empty, idle block. The second load then meets the engine's take of the first, and the bench expects exactly one free entry gone afterwards. It then loads past the capacity and counts select frames on the pins, which must equal the accepted words and exclude the ignored one. The receive side has the same kind of meeting between a finished word and a full queue; this is judged by the overflow flag and by the oldest-first contents that remain.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W);
  localparam int DLY_W  = 8;

  typedef struct packed {
    logic [LEN_W-1:0] len_m1;
    logic [DLY_W-1:0] half;
    logic             msb_first;
    logic             sample_fall;
    logic             cpol;
    logic [1:0]       frame_mode;
    logic             ss_low;
    logic             write_only;
  } spi_cfg_t;

  localparam spi_cfg_t CFG_DEFAULT = '{
    len_m1: LEN_W'(7), half: '0, msb_first: 1'b0, sample_fall: 1'b0,
    cpol: 1'b0, frame_mode: 2'd0, ss_low: 1'b0, write_only: 1'b0};

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_PGAP, ST_LEAD, ST_TRAIL, ST_QGAP, ST_POST
  } eng_st_e;
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rd_q];
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push) wr_q <= nxt(wr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= wdata_i;
  end

  assert_full_push_dropped_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (count_o == CW'(DEPTH)));
  assert_count_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
  import spi_fm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  spi_cfg_t          cfg_i,
  input  logic              abort_i,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              busy_o,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              ss_o
);
  eng_st_e           state_q;
  logic [DLY_W-1:0]  tick_q;
  logic [LEN_W-1:0]  bit_q;
  logic [WORD_W-1:0] word_q, rxw_q;
  logic              half_end, last_bit, in_data, ss_act;
  logic [LEN_W-1:0]  idx;

  assign half_end = (tick_q == cfg_i.half);
  assign last_bit = (bit_q == cfg_i.len_m1);
  assign idx      = cfg_i.msb_first ? (cfg_i.len_m1 - bit_q) : bit_q;
  assign in_data  = (state_q == ST_LEAD) || (state_q == ST_TRAIL);
  assign busy_o   = (state_q != ST_IDLE);
  assign tx_pop_o = (state_q == ST_IDLE) && tx_valid_i && !abort_i;
  assign rx_push_o = (state_q == ST_TRAIL) && half_end && last_bit &&
                     !cfg_i.write_only && !abort_i;
  assign rx_word_o = rxw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      word_q  <= '0;
      rxw_q   <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (tx_valid_i) begin
        word_q  <= tx_data_i;
        rxw_q   <= '0;
        bit_q   <= '0;
        tick_q  <= '0;
        state_q <= cfg_i.frame_mode[0] ? ST_PRE : ST_LEAD;
      end
    end else if (!half_end) begin
      tick_q <= tick_q + 1'b1;
    end else begin
      tick_q <= '0;
      unique case (state_q)
        ST_PRE:  state_q <= ST_PGAP;
        ST_PGAP: state_q <= ST_LEAD;
        ST_LEAD: begin
          rxw_q[idx] <= miso_i;
          state_q    <= ST_TRAIL;
        end
        ST_TRAIL: begin
          if (last_bit) state_q <= cfg_i.frame_mode[1] ? ST_QGAP : ST_IDLE;
          else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_LEAD;
          end
        end
        ST_QGAP: state_q <= ST_POST;
        ST_POST: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // lead level equals the sample-edge bit, so the lead->trail edge is the sampling edge
  always_comb begin
    unique case (state_q)
      ST_LEAD:  sclk_o = cfg_i.sample_fall;
      ST_TRAIL: sclk_o = !cfg_i.sample_fall;
      default:  sclk_o = cfg_i.cpol;
    endcase
  end

  assign ss_act = (state_q == ST_PRE) || (state_q == ST_POST) ||
                  ((cfg_i.frame_mode == 2'd0) && in_data);
  assign ss_o   = ss_act ^ cfg_i.ss_low;
  assign mosi_o = in_data ? word_q[idx] : 1'b0;

  assert_tick_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (tick_q <= cfg_i.half));
  assert_bit_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (bit_q <= cfg_i.len_m1));
  assert_mosi_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_LEAD && state_q == ST_TRAIL) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fm_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int TCW     = $clog2(TX_DEPTH + 1),
  localparam int RCW     = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  cfg_len_m1_i,
  input  logic [DLY_W-1:0]  cfg_half_i,
  input  logic              cfg_msb_first_i,
  input  logic              cfg_sample_fall_i,
  input  logic              cfg_cpol_i,
  input  logic [1:0]        cfg_frame_mode_i,
  input  logic              cfg_ss_low_i,
  input  logic              cfg_write_only_i,
  input  logic              restart_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              clr_rx_i,
  input  logic              rx_pop_i,
  input  logic              miso_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic [TCW-1:0]    tx_space_o,
  output logic [RCW-1:0]    rx_count_o,
  output logic              idle_o,
  output logic              rx_overflow_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              ss_o
);
  spi_cfg_t          cfg_q;
  logic [WORD_W-1:0] tx_head, rx_word;
  logic [TCW-1:0]    tx_cnt;
  logic              tx_full, tx_empty, tx_pop;
  logic              rx_full, rx_empty, rx_push, busy, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_DEFAULT;
    else if (restart_i)
      cfg_q <= '{len_m1: cfg_len_m1_i, half: cfg_half_i, msb_first: cfg_msb_first_i,
                 sample_fall: cfg_sample_fall_i, cpol: cfg_cpol_i,
                 frame_mode: cfg_frame_mode_i, ss_low: cfg_ss_low_i,
                 write_only: cfg_write_only_i};
  end

  spi_fm_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(restart_i), .push_i(load_i), .wdata_i(load_data_i),
    .pop_i(tx_pop), .rdata_o(tx_head), .count_o(tx_cnt), .full_o(tx_full),
    .empty_o(tx_empty));

  spi_fm_engine u_engine (
    .clk_i, .rst_ni, .cfg_i(cfg_q), .abort_i(restart_i), .tx_valid_i(!tx_empty),
    .tx_data_i(tx_head), .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_word_o(rx_word),
    .busy_o(busy), .miso_i, .sclk_o, .mosi_o, .ss_o);

  spi_fm_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(clr_rx_i), .push_i(rx_push), .wdata_i(rx_word),
    .pop_i(rx_pop_i), .rdata_o(rx_data_o), .count_o(rx_count_o), .full_o(rx_full),
    .empty_o(rx_empty));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else if (clr_rx_i) ovf_q <= 1'b0;
    else if (rx_push && rx_full && !rx_pop_i) ovf_q <= 1'b1;
  end

  assign rx_overflow_o = ovf_q;
  assign tx_space_o    = TCW'(TX_DEPTH) - tx_cnt;
  assign idle_o        = !busy && tx_empty;

  assert_restart_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (tx_space_o == TCW'(TX_DEPTH)) && idle_o);
  assert_overflow_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_overflow_o && !clr_rx_i) |=> rx_overflow_o);
  assert_write_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.write_only && !restart_i) |=> (rx_count_o <= $past(rx_count_o)));
  assert_idle_clock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (sclk_o == cfg_q.cpol));
  assert_rx_not_empty_ok_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty && !rx_push) |=> (rx_count_o == '0 || clr_rx_i || $past(clr_rx_i)) || rx_count_o == '0);
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 4;
  localparam int RXD = 4;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0]  cfg_len_m1_i = 5'd7;
  logic [7:0]  cfg_half_i = '0;
  logic        cfg_msb_first_i = 0, cfg_sample_fall_i = 0, cfg_cpol_i = 0;
  logic [1:0]  cfg_frame_mode_i = '0;
  logic        cfg_ss_low_i = 0, cfg_write_only_i = 0;
  logic        restart_i = 0, load_i = 0, clr_rx_i = 0, rx_pop_i = 0;
  logic [31:0] load_data_i = '0;
  logic        miso_i;
  logic [31:0] rx_data_o;
  logic [2:0]  tx_space_o, rx_count_o;
  logic        idle_o, rx_overflow_o, sclk_o, mosi_o, ss_o;

  spi_fifo_master #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (.*);

  assign miso_i = ~mosi_o;  // slave echoes inverted data
  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench copy of applied settings, defaults match the post-reset values
  int b_len = 8, b_half = 0, b_mode = 0;
  bit b_msb = 0, b_fall = 0, b_cpol = 0, b_low = 0, b_wo = 0;

  // pin monitor
  bit mon_en = 0;
  int nc = 0, tog_cnt = 0, sp_err = 0, nbits = 0, runs = 0, run_len = 0;
  int run1_len = 0, run2_len = 0, act_tog = 0, frames = 0;
  int f_fall_nc = 0, l_rise_nc = 0, f_edge_nc = 0, l_edge_nc = 0;
  bit seen_tog = 0, act_prev = 0, prev_sclk = 0, first_bit = 0;
  logic [31:0] mword = '0;

  always @(negedge clk_i) begin
    bit act, smp;
    nc++;
    act = ss_o ^ b_low;
    if (act && !act_prev && b_mode == 0) frames++;
    if (mon_en) begin
      if (sclk_o != prev_sclk) begin
        if (seen_tog && tog_cnt != b_half + 1) sp_err++;
        seen_tog = 1;
        tog_cnt = 1;
        if (act && b_mode != 0) act_tog++;
        smp = b_fall ? (prev_sclk && !sclk_o) : (!prev_sclk && sclk_o);
        if (smp) begin
          if (nbits == 0) begin first_bit = mosi_o; f_edge_nc = nc; end
          if (nbits < b_len) mword[b_msb ? b_len - 1 - nbits : nbits] = mosi_o;
          nbits++;
          l_edge_nc = nc;
        end
      end else tog_cnt++;
      if (act) begin
        if (!act_prev) begin l_rise_nc = nc; run_len = 0; end
        run_len++;
      end else if (act_prev) begin
        runs++;
        if (runs == 1) begin run1_len = run_len; f_fall_nc = nc; end
        else run2_len = run_len;
      end
      prev_sclk = sclk_o;
    end
    act_prev = act;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    mon_en = 0;
    tog_cnt = 0; sp_err = 0; nbits = 0; runs = 0; run_len = 0; run1_len = 0;
    run2_len = 0; act_tog = 0; seen_tog = 0; first_bit = 0; mword = '0;
    f_fall_nc = 0; l_rise_nc = 0; f_edge_nc = 0; l_edge_nc = 0;
    prev_sclk = b_cpol;
    mon_en = 1;
  endtask

  task automatic apply_cfg(input int len, input int half, input bit msb, input bit fall,
                           input bit cpol, input int mode, input bit low, input bit wo,
                           input bit clr);
    mon_en = 0;
    @(negedge clk_i);
    cfg_len_m1_i = 5'(len - 1); cfg_half_i = 8'(half); cfg_msb_first_i = msb;
    cfg_sample_fall_i = fall; cfg_cpol_i = cpol; cfg_frame_mode_i = 2'(mode);
    cfg_ss_low_i = low; cfg_write_only_i = wo;
    restart_i = 1; clr_rx_i = clr;
    @(negedge clk_i);
    restart_i = 0; clr_rx_i = 0;
    b_len = len; b_half = half; b_msb = msb; b_fall = fall; b_cpol = cpol;
    b_mode = mode; b_low = low; b_wo = wo;
  endtask

  task automatic pulse_pop();
    rx_pop_i = 1;
    @(negedge clk_i);
    rx_pop_i = 0;
  endtask

  task automatic wait_idle();
    while (!idle_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_word(input logic [31:0] data);
    logic [31:0] mask, expw;
    int h1, want_bit;
    mon_clear();
    load_i = 1; load_data_i = data;
    @(negedge clk_i);
    load_i = 0;
    chk(idle_o == 1'b0, "R12 idle low while word pending", idle_o, 0);
    wait_idle();
    mask = (b_len == 32) ? 32'hFFFF_FFFF : ((32'd1 << b_len) - 1);
    expw = data & mask;
    h1 = b_half + 1;
    chk(nbits == b_len, "R1 bits per word", nbits, b_len);
    chk(mword == expw, "R4 bits seen on sampling edges", mword, expw);
    want_bit = b_msb ? data[b_len-1] : data[0];
    chk(first_bit == want_bit, "R3 first bit on the wire", first_bit, want_bit);
    chk(sp_err == 0, "R2 half-period length", sp_err, 0);
    chk(sclk_o == b_cpol, "R5 clock rest level", sclk_o, b_cpol);
    chk(ss_o == b_low, "R7 select inactive level", ss_o, b_low);
    chk(act_tog == 0, "R5 clock quiet during select pulse", act_tog, 0);
    case (b_mode)
      0: chk(runs == 1 && run1_len == 2 * b_len * h1, "R6 select spans data", run1_len, 2 * b_len * h1);
      1: begin
        chk(runs == 1 && run1_len == h1, "R6 pre pulse width", run1_len, h1);
        chk(f_edge_nc - f_fall_nc == 2 * h1, "R6 pre pulse gap", f_edge_nc - f_fall_nc, 2 * h1);
      end
      2: begin
        chk(runs == 1 && run1_len == h1, "R6 post pulse width", run1_len, h1);
        chk(l_rise_nc - l_edge_nc == 2 * h1, "R6 post pulse gap", l_rise_nc - l_edge_nc, 2 * h1);
      end
      default: begin
        chk(runs == 2 && run1_len == h1 && run2_len == h1, "R6 both pulses", runs, 2);
        chk(f_edge_nc - f_fall_nc == 2 * h1, "R6 pre gap both", f_edge_nc - f_fall_nc, 2 * h1);
        chk(l_rise_nc - l_edge_nc == 2 * h1, "R6 post gap both", l_rise_nc - l_edge_nc, 2 * h1);
      end
    endcase
    chk(tx_space_o == TXD, "R12 tx space after word", tx_space_o, TXD);
    if (b_wo) chk(rx_count_o == 0, "R8 write-only stores nothing", rx_count_o, 0);
    else begin
      chk(rx_count_o == 1, "R13 one word stored", rx_count_o, 1);
      chk(rx_data_o == (~data & mask), "R13 received word", rx_data_o, ~data & mask);
      pulse_pop();
    end
    mon_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lens[6] = '{1, 2, 5, 8, 13, 32};
    int k = 0;
    logic [31:0] w;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    chk(idle_o && tx_space_o == TXD && rx_count_o == 0, "R12 reset status", {idle_o, tx_space_o, rx_count_o}, {1'b1, 3'(TXD), 3'd0});
    chk(rx_overflow_o == 0, "R9 reset overflow", rx_overflow_o, 0);
    chk(sclk_o == 0 && ss_o == 0, "R5 R7 reset pins", {sclk_o, ss_o}, 0);
    // defaults from rst_ni: 8 bits, lsb first, rising sample, rest low, select spans word, active high
    run_word(32'h0000_01A5);

    // sweep
    for (int li = 0; li < 6; li++)
      for (int msb = 0; msb < 2; msb++)
        for (int fall = 0; fall < 2; fall++)
          for (int cpol = 0; cpol < 2; cpol++)
            for (int mode = 0; mode < 4; mode++) begin
              k++;
              apply_cfg(lens[li], k % 3, msb[0], fall[0], cpol[0], mode,
                        mode[0] ^ lens[li][0], (mode == 2) && cpol && fall, 1'b1);
              w = (32'h9E37_79B9 * k) ^ (k << 7);
              run_word(w);
            end

    // receive overflow, order, sticky flag, clear (R9 R11 R13)
    apply_cfg(8, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      load_i = 1; load_data_i = 32'(i * 17 + 3);
      @(negedge clk_i);
    end
    load_i = 0;
    wait_idle();
    chk(rx_count_o == RXD, "R9 queue full", rx_count_o, RXD);
    chk(rx_overflow_o == 1, "R9 overflow set", rx_overflow_o, 1);
    for (int i = 0; i < 4; i++) begin
      chk(rx_data_o == (~32'(i * 17 + 3) & 32'hFF), "R13 oldest first", rx_data_o, ~32'(i * 17 + 3) & 32'hFF);
      pulse_pop();
    end
    chk(rx_overflow_o == 1, "R9 overflow sticky", rx_overflow_o, 1);
    clr_rx_i = 1; @(negedge clk_i); clr_rx_i = 0;
    chk(rx_overflow_o == 0, "R11 clear drops overflow", rx_overflow_o, 0);

    // clear during transmit leaves transmit alone (R11)
    apply_cfg(32, 3, 1, 0, 0, 0, 0, 0, 1'b1);
    load_i = 1; load_data_i = 32'h1234_5678; @(negedge clk_i);
    load_data_i = 32'h0F0F_AAAA; @(negedge clk_i);
    load_i = 0;
    repeat (10) @(negedge clk_i);
    clr_rx_i = 1; @(negedge clk_i); clr_rx_i = 0;
    wait_idle();
    chk(rx_count_o == 2, "R11 transmit unaffected by clear", rx_count_o, 2);
    chk(rx_data_o == ~32'h1234_5678, "R11 first word intact", rx_data_o, ~32'h1234_5678);
    pulse_pop();
    chk(rx_data_o == ~32'h0F0F_AAAA, "R11 second word intact", rx_data_o, ~32'h0F0F_AAAA);
    pulse_pop();

    // restart aborts (R10)
    apply_cfg(32, 5, 0, 0, 0, 0, 0, 0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      load_i = 1; load_data_i = 32'hDEAD_0000 + 32'(i); @(negedge clk_i);
    end
    load_i = 0;
    repeat (20) @(negedge clk_i);
    apply_cfg(8, 0, 0, 0, 1, 0, 1, 0, 1'b0);
    chk(tx_space_o == TXD, "R10 transmit flushed", tx_space_o, TXD);
    chk(idle_o == 1, "R10 idle after restart", idle_o, 1);
    chk(sclk_o == 1, "R10 new rest level", sclk_o, 1);
    chk(ss_o == 1, "R10 select inactive", ss_o, 1);
    repeat (50) @(negedge clk_i);
    chk(rx_count_o == 0, "R10 aborted word not stored", rx_count_o, 0);

    // load meets engine take (R12)
    apply_cfg(32, 2, 0, 0, 0, 0, 0, 1, 1'b1);
    frames = 0;
    load_i = 1; load_data_i = 32'h1; @(negedge clk_i);
    load_data_i = 32'h2; @(negedge clk_i);
    load_i = 0;
    chk(tx_space_o == TXD - 1, "R12 load during take", tx_space_o, TXD - 1);
    for (int i = 0; i < 4; i++) begin
      load_i = 1; load_data_i = 32'(i + 3); @(negedge clk_i);
    end
    load_i = 0;
    chk(tx_space_o == 0, "R12 queue full", tx_space_o, 0);
    wait_idle();
    chk(frames == 5, "R12 load into full queue ignored", frames, 5);
    chk(rx_count_o == 0, "R8 write-only burst", rx_count_o, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule